// File: doc/BRIEF.md
# I2C Serial Memory Target

This block is an I2C target that sits in front of a 1024-byte on-chip store and behaves like a small serial EEPROM. It watches SCL and SDA, which are already synchronized to the fast system clock. It finds START, repeated START and STOP conditions. It decodes a device-select byte and a byte address, and it answers with an open-drain drive-low enable on SDA. Writes come in two forms: a single byte, or a burst of bytes that stays inside an aligned block of the store.

Reads come in three forms, and all three share one internal address counter. The counter is loaded by a dummy write, and it steps forward after every byte the target sends. A controller can therefore:

- read the byte at the current counter,
- set the counter and then read,
- keep a read going for as long as it acknowledges each byte.

A write-lock input stops any data from being stored. While it is high, the device-select and address bytes are still acknowledged.

Top module: `serial_mem_target`

## Requirements
- R1: After reset, `sda_oe` is low and every one of the 1024 locations reads as 8'hFF until it is written.
- R2: A device-select byte is acknowledged only when its bits [7:3] equal 5'b10100. Bits [2:1] give address bits [9:8], and bit 0 gives the direction (1 read, 0 write). A non-matching byte and every later byte up to the next START get no acknowledge.
- R3: A byte write has three parts: a write device-select, an address byte (address bits [7:0]) and a data byte. The target acknowledges each of the three parts and stores the data byte at the 10-bit address.
- R4: After each stored data byte, the write address advances inside an aligned block and wraps within it. The block is 16 bytes when `page_mode` is 1 and 4 bytes when `page_mode` is 0. The address bits above the block never change.
- R5: While `wr_lock` is 1, the device-select and address bytes are acknowledged. Every data byte is refused with no acknowledge, and memory is left unchanged.
- R6: Random read works as follows:
  - A write device-select and an address byte load the counter.
  - A repeated START and a read device-select follow.
  - The target returns the byte at the loaded address.
- R7: Current-address read works as follows:
  - A read device-select right after START loads counter bits [9:8] from the select byte.
  - The target returns the byte at the counter.
  - The counter advances by one after each byte sent.
- R8: When the controller acknowledges a sent byte, the target sends the next byte. The read address wraps from 1023 to 0.
- R9: When the controller does not acknowledge a sent byte, the target releases SDA and sends nothing more. A STOP leaves `sda_oe` low.
- R10: Read data and read sequencing do not depend on the level of `page_mode`.
- R11: A START in the middle of a byte abandons that byte, and the next byte is decoded as a device-select. A STOP in the middle of a data byte abandons it without storing anything.
- R12: `sda_oe` only changes while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Synchronized I2C clock line |
| sda_in | input | 1 | Synchronized I2C data line (bus level) |
| wr_lock | input | 1 | 1 refuses all data bytes of writes |
| page_mode | input | 1 | Write wrap block: 1 gives 16 bytes, 0 gives 4 bytes |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |

## Verification
Every location is swept once after reset, so the all-ones content and the 1023-to-0 rollover are both exercised.

Bursts longer than the wrap block are written in each `page_mode` setting. Reading the block back tells in-block wrapping apart from a plain linear increment, and it also shows that the last write to a location wins.

The same region is then read back under both `page_mode` levels. Locked writes, a foreign device-select, and START or STOP cutting into a byte each have their own check. These checks separate a refused or abandoned byte from one that was stored.

// File: rtl/smt_pkg.sv
// Shared types for the serial memory target.
// Assumes: single clock domain, all users import this package.
package smt_pkg;

    // Transfer phases of the target engine.
    typedef enum logic [3:0] {
        ST_IDLE,      // not addressed, waiting for START
        ST_DEV,       // shifting in the device-select byte
        ST_DEV_ACK,   // answering the device-select byte
        ST_ADDR,      // shifting in the byte address
        ST_ADDR_ACK,  // answering the address byte
        ST_WDATA,     // shifting in a write data byte
        ST_WDATA_ACK, // answering (or refusing) a data byte
        ST_TX,        // shifting out a read data byte
        ST_TX_ACK     // sampling the controller acknowledge
    } smt_state_e;

endpackage

// File: rtl/smt_line_watch.sv
// Bus condition detector: turns the synchronized SCL/SDA levels into
// single-cycle events for SCL edges, START and STOP.
// Assumes: inputs are already synchronized; each SCL level lasts at least
// two system clocks.
module smt_line_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_seen,
    output logic stop_seen
);

    logic scl_q;
    logic sda_q;

    // Keep the line levels from the previous clock (idle high after reset).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_in;
            sda_q <= sda_in;
        end
    end

    // Events: SCL edges, and SDA edges while SCL stays high.
    always_comb begin
        scl_rise   = scl_in & ~scl_q;
        scl_fall   = ~scl_in & scl_q;
        start_seen = scl_in & scl_q & sda_q & ~sda_in;
        stop_seen  = scl_in & scl_q & ~sda_q & sda_in;
    end

endmodule

// File: rtl/smt_store.sv
// Byte store with a per-location written flag: an unwritten location reads
// all ones, so only the flag vector needs reset and the data array can map
// to RAM.
// Assumes: one write port, combinational read.
module smt_store #(
    parameter int DEPTH = 1024,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0]    cells [DEPTH];
    logic [DEPTH-1:0] written;

    // Data array write; no reset, contents masked by the written flags.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // Written flags: cleared by reset, set on each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            written <= '0;
        end else if (we) begin
            written[waddr] <= 1'b1;
        end
    end

    // Read path: erased locations return all ones.
    always_comb begin
        rdata = written[raddr] ? cells[raddr] : {DW{1'b1}};
    end

endmodule

// File: rtl/smt_engine.sv
// Transfer engine: decodes device-select, address and data bytes, keeps
// the shared address counter, shifts read data out and drives the
// drive-low enable for ACK and data bits.
// Assumes: events come from smt_line_watch; the store reads combinationally.
module smt_engine
    import smt_pkg::*;
#(
    parameter int         AW          = 10,
    parameter int         PAGE_BYTES  = 16,
    parameter int         GROUP_BYTES = 4,
    parameter logic [7:0] DEV_TAG     = 8'hA0,
    localparam int        HI_W        = AW - 8,
    localparam int        PG_W        = $clog2(PAGE_BYTES),
    localparam int        GR_W        = $clog2(GROUP_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          bus_start,
    input  logic          bus_stop,
    input  logic          sda_in,
    input  logic          wr_lock,
    input  logic          page_mode,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [7:0]    mem_wdata,
    output logic          sda_oe
);

    smt_state_e    state;
    logic [3:0]    bit_cnt;
    logic [7:0]    rx_sh;
    logic [7:0]    tx_sh;
    logic [AW-1:0] cnt;
    logic          is_read;
    logic          ctl_ack;
    logic          rx_phase;
    logic          byte_done;
    logic          tag_hit;
    logic [AW-1:0] wr_next;

    // Decode helpers: receive phase, end of an 8-bit byte, select match.
    always_comb begin
        rx_phase  = (state == ST_DEV) || (state == ST_ADDR) || (state == ST_WDATA);
        byte_done = scl_fall && (bit_cnt == 4'd8);
        tag_hit   = (rx_sh[7:HI_W+1] == DEV_TAG[7:HI_W+1]);
    end

    // Next write address: step inside the 16-byte page or the 4-byte group.
    always_comb begin
        if (page_mode) begin
            wr_next = {cnt[AW-1:PG_W], cnt[PG_W-1:0] + 1'b1};
        end else begin
            wr_next = {cnt[AW-1:GR_W], cnt[GR_W-1:0] + 1'b1};
        end
    end

    assign rd_addr = cnt;

    // Main sequencer: bus conditions first, then per-phase bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            cnt       <= '0;
            is_read   <= 1'b0;
            ctl_ack   <= 1'b0;
            mem_we    <= 1'b0;
            mem_waddr <= '0;
            mem_wdata <= '0;
            sda_oe    <= 1'b0;
        end else begin
            mem_we <= 1'b0;
            if (bus_stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (bus_start) begin
                state   <= ST_DEV;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else begin
                if (rx_phase && scl_rise) begin
                    rx_sh   <= {rx_sh[6:0], sda_in};
                    bit_cnt <= bit_cnt + 1'b1;
                end
                case (state)
                    ST_DEV: if (byte_done) begin
                        bit_cnt <= '0;
                        if (tag_hit) begin
                            sda_oe        <= 1'b1;
                            is_read       <= rx_sh[0];
                            cnt[AW-1:8]   <= rx_sh[HI_W:1];
                            state         <= ST_DEV_ACK;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                    ST_ADDR: if (byte_done) begin
                        bit_cnt  <= '0;
                        sda_oe   <= 1'b1;
                        cnt[7:0] <= rx_sh;
                        state    <= ST_ADDR_ACK;
                    end
                    ST_WDATA: if (byte_done) begin
                        bit_cnt <= '0;
                        if (!wr_lock) begin
                            sda_oe    <= 1'b1;
                            mem_we    <= 1'b1;
                            mem_waddr <= cnt;
                            mem_wdata <= rx_sh;
                            cnt       <= wr_next;
                        end
                        state <= ST_WDATA_ACK;
                    end
                    ST_DEV_ACK: if (scl_fall) begin
                        if (is_read) begin
                            tx_sh  <= rd_data;
                            sda_oe <= ~rd_data[7];
                            cnt    <= cnt + 1'b1;
                            state  <= ST_TX;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_ADDR;
                        end
                    end
                    ST_ADDR_ACK, ST_WDATA_ACK: if (scl_fall) begin
                        sda_oe <= 1'b0;
                        state  <= ST_WDATA;
                    end
                    ST_TX: if (scl_fall) begin
                        if (bit_cnt == 4'd7) begin
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                            state   <= ST_TX_ACK;
                        end else begin
                            tx_sh   <= {tx_sh[6:0], 1'b0};
                            sda_oe  <= ~tx_sh[6];
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) begin
                            ctl_ack <= ~sda_in;
                        end else if (scl_fall) begin
                            if (ctl_ack) begin
                                tx_sh  <= rd_data;
                                sda_oe <= ~rd_data[7];
                                cnt    <= cnt + 1'b1;
                                state  <= ST_TX;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/serial_mem_target.sv
// Top level of the I2C serial memory target: line watcher, transfer engine
// and byte store.
// Assumes: SCL/SDA synchronized to clk; the SDA pad is open drain and
// pulled low while sda_oe is 1.
module serial_mem_target #(
    parameter int         MEM_BYTES   = 1024,
    parameter int         PAGE_BYTES  = 16,
    parameter int         GROUP_BYTES = 4,
    parameter logic [7:0] DEV_TAG     = 8'hA0,
    localparam int        AW          = $clog2(MEM_BYTES)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic wr_lock,
    input  logic page_mode,
    output logic sda_oe
);

    logic          scl_rise;
    logic          scl_fall;
    logic          bus_start;
    logic          bus_stop;
    logic [7:0]    rd_data;
    logic [AW-1:0] rd_addr;
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [7:0]    mem_wdata;

    smt_line_watch u_watch (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (scl_in),
        .sda_in     (sda_in),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_seen (bus_start),
        .stop_seen  (bus_stop)
    );

    smt_engine #(
        .AW          (AW),
        .PAGE_BYTES  (PAGE_BYTES),
        .GROUP_BYTES (GROUP_BYTES),
        .DEV_TAG     (DEV_TAG)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .sda_in    (sda_in),
        .wr_lock   (wr_lock),
        .page_mode (page_mode),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .sda_oe    (sda_oe)
    );

    smt_store #(
        .DEPTH (MEM_BYTES),
        .DW    (8)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

endmodule

// File: rtl/serial_mem_target_chk.sv
// Protocol checker for serial_mem_target, attached by bind.
// Assumes: synchronous active-low reset held for at least one clock.
module serial_mem_target_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_in,
    input logic sda_in,
    input logic wr_lock,
    input logic sda_oe,
    input logic mem_we
);

    AST_OE_MOVES_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_in); // R12

    AST_STOP_RELEASES_SDA: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_in && $past(scl_in) && !$past(sda_in) && sda_in) |=> !sda_oe); // R9

    AST_START_RELEASES_SDA: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_in && $past(scl_in) && $past(sda_in) && !sda_in) |=> !sda_oe); // R11

    AST_NO_STORE_WHEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !$past(wr_lock)); // R5

endmodule

bind serial_mem_target serial_mem_target_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_in  (scl_in),
    .sda_in  (sda_in),
    .wr_lock (wr_lock),
    .sda_oe  (sda_oe),
    .mem_we  (mem_we)
);

// File: tb/serial_mem_target_tb.sv
// Self-checking bench: acts as the I2C controller, keeps a reference copy of
// memory and compares every byte read back.
module serial_mem_target_tb;

    localparam int Q = 2; // system clocks per quarter SCL period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic wr_lock = 1'b0;
    logic page_mode = 1'b1;
    logic sda_oe;
    logic sda_bus;

    int compared = 0;
    int mismatched = 0;
    int oe_viol = 0;
    logic oe_prev = 1'b0;
    logic [7:0] mdl [1024];
    int ptr = 0;

    assign sda_bus = sda_m & ~sda_oe;

    always #10 clk = ~clk; // 50 MHz

    serial_mem_target u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl),
        .sda_in    (sda_bus),
        .wr_lock   (wr_lock),
        .page_mode (page_mode),
        .sda_oe    (sda_oe)
    );

    // R12 monitor: sda_oe must not move while SCL is high.
    always @(posedge clk) begin
        #1;
        if (rst_n && (sda_oe !== oe_prev) && scl) oe_viol++;
        oe_prev = sda_oe;
    end

    task automatic chk(input string req, input int act, input int exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); b = sda_bus; wq(Q); scl = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output bit ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = !b;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!give_ack);
    endtask

    function automatic logic [7:0] dsel(input int a, input bit rd);
        return {5'b10100, a[9:8], rd};
    endfunction

    function automatic int wnext(input int a);
        if (page_mode) return (a & ~15) | ((a + 1) & 15);
        return (a & ~3) | ((a + 1) & 3);
    endfunction

    // Write n bytes starting at a; data value depends on seed and index.
    task automatic write_seq(input int a, input int n, input int seed,
                             input bit exp_ack, input string req);
        bit ak;
        int cur = a;
        logic [7:0] v;
        bus_start;
        send_byte(dsel(a, 0), ak); chk(req, ak, 1);
        send_byte(a[7:0], ak);     chk(req, ak, 1);
        for (int i = 0; i < n; i++) begin
            v = 8'((seed + i * 37) & 255);
            send_byte(v, ak);
            chk(req, ak, exp_ack);
            if (exp_ack) begin
                mdl[cur] = v;
                cur = wnext(cur);
            end
        end
        bus_stop;
    endtask

    // Random-address read of n bytes, acknowledging all but the last.
    task automatic read_seq(input int a, input int n, input string req);
        bit ak;
        logic [7:0] v;
        bus_start;
        send_byte(dsel(a, 0), ak); chk(req, ak, 1);
        send_byte(a[7:0], ak);     chk(req, ak, 1);
        bus_start;
        send_byte(dsel(a, 1), ak); chk(req, ak, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, v);
            chk(req, v, mdl[(a + i) % 1024]);
        end
        bus_stop;
        ptr = (a + n) % 1024;
    endtask

    // Current-address read of n bytes.
    task automatic cur_read(input int n, input string req);
        bit ak;
        logic [7:0] v;
        bus_start;
        send_byte(dsel(ptr, 1), ak); chk(req, ak, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, v);
            chk(req, v, mdl[(ptr + i) % 1024]);
        end
        bus_stop;
        ptr = (ptr + n) % 1024;
    endtask

    task automatic report;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual running expected done");
        report;
    end

    initial begin
        bit ak;
        logic [7:0] v;
        for (int i = 0; i < 1024; i++) mdl[i] = 8'hFF;
        wq(5);
        rst_n = 1'b1;
        wq(2);
        chk("R1", sda_oe, 0);

        // R1, R8: whole store reads all ones after reset
        read_seq(0, 1024, "R1");

        // R3, R6: single byte write then random read
        write_seq(12'h123, 1, 8'h5A, 1, "R3");
        read_seq(12'h123, 1, "R6");

        // R4: 16-byte page wrap, burst longer than the page
        write_seq(12'h2FC, 20, 3, 1, "R4");
        read_seq(12'h2F0, 16, "R4");

        // R4: 4-byte group wrap; R10: read result independent of page_mode
        page_mode = 1'b0;
        write_seq(12'h041, 6, 11, 1, "R4");
        read_seq(12'h040, 8, "R10");
        page_mode = 1'b1;
        read_seq(12'h040, 8, "R10");

        // R5: locked writes refused, memory unchanged
        wr_lock = 1'b1;
        write_seq(12'h123, 3, 0, 0, "R5");
        wr_lock = 1'b0;
        read_seq(12'h120, 8, "R5");

        // R8: sequential read across 1023 -> 0; R7: current-address read
        write_seq(12'h3FF, 1, 8'hC1, 1, "R3");
        write_seq(12'h000, 1, 8'hC2, 1, "R3");
        write_seq(12'h001, 1, 8'hC3, 1, "R3");
        write_seq(12'h002, 1, 8'hC4, 1, "R3");
        read_seq(12'h3FE, 3, "R8");
        cur_read(2, "R7");
        cur_read(1, "R7");

        // R2: foreign device-select and following byte not acknowledged
        bus_start;
        send_byte(8'hB0, ak); chk("R2", ak, 0);
        send_byte(8'h00, ak); chk("R2", ak, 0);
        bus_stop;
        chk("R2", sda_oe, 0);

        // R11: START cutting into a device-select byte
        bus_start;
        for (int i = 7; i >= 4; i--) put_bit(dsel(12'h050, 0) >> i);
        write_seq(12'h050, 1, 8'h77, 1, "R11");
        read_seq(12'h050, 1, "R11");

        // R11: STOP cutting into a data byte stores nothing
        bus_start;
        send_byte(dsel(12'h060, 0), ak); chk("R11", ak, 1);
        send_byte(8'h60, ak);            chk("R11", ak, 1);
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
        bus_stop;
        read_seq(12'h060, 1, "R11");

        // R9: NACK ends the read and SDA is released
        bus_start;
        send_byte(dsel(ptr, 1), ak); chk("R9", ak, 1);
        recv_byte(1'b0, v);
        chk("R9", v, mdl[ptr]);
        wq(2);
        chk("R9", sda_oe, 0);
        bus_stop;
        wq(2);
        chk("R9", sda_oe, 0);

        chk("R12", oe_viol, 0);
        report;
    end

endmodule